// File: doc/BRIEF.md
# Overload Retry Duty-Cycle Timer

This block sets the restart pattern of a switching output once an overload has been reported. While no overload is present, the output enable stays asserted. When the overload flag is seen, the output is switched off. The block then repeats a fixed cycle: it keeps the output off for several test intervals, and then turns it on for exactly one test interval to probe the load. The overload flag is checked on the last cycle of each probe. If the flag is still set, a new off period starts. If it has cleared, the output stays on and the block goes back to normal operation.

The probe length is fixed by a build-time parameter (`TEST_CYC` clock cycles). Only the ratio of on-time to the whole retry period can be set at run time. This is done through a 2-bit ratio field supplied by a configuration register outside the block. A ratio of 1:N gives one probe interval followed by N-1 off intervals, so each period lasts N·`TEST_CYC` cycles. The ratio field is captured once at the start of each retry period, so writing a new value never disturbs a period that is already running. A status output reports that the block is in retry operation.

Top module: `ovr_retry_timer`

## Requirements
- R1: While rst_ni is low, out_en_o is 1 and ovl_stat_o is 0, and both take these values without waiting for a clock edge.
- R2: In normal operation with ovl_i low at a rising edge, the next cycle still shows out_en_o = 1 and ovl_stat_o = 0, whatever value duty_sel_i has.
- R3: In normal operation with ovl_i high at a rising edge, the next cycle shows out_en_o = 0 and ovl_stat_o = 1. This first cycle is the start of a retry period.
- R4: Each probe pulse keeps out_en_o at 1 for exactly TEST_CYC consecutive cycles, for every ratio setting.
- R5: duty_sel_i selects N as follows: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 10 and 2'b11 gives 15. A retry period lasts N·TEST_CYC cycles: first (N-1)·TEST_CYC cycles with out_en_o = 0, then the probe pulse.
- R6: ovl_i is used only at the rising edge that ends the last probe cycle. If it is high there, the next cycle starts a new retry period with out_en_o = 0. Changes of ovl_i earlier in the probe do not affect the outputs.
- R7: If ovl_i is low at the rising edge that ends the last probe cycle, the next cycle shows out_en_o = 1 and ovl_stat_o = 0, and normal operation resumes.
- R8: duty_sel_i is captured at the rising edge that starts a retry period, whether that edge enters retry or restarts it. The captured value sets N for that whole period, and a change made later in the period takes effect only from the next period.
- R9: ovl_stat_o is 1 on every cycle of retry operation, including the probe cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ovl_i | input | 1 | Overload flag from the current sensing |
| duty_sel_i | input | 2 | Retry ratio field from the configuration register |
| out_en_o | output | 1 | Output enable gating for the switch |
| ovl_stat_o | output | 1 | Retry operation in progress |

## Verification
Two things can happen at the same rising edge: the overload decision at the end of a probe, and the capture of the ratio for the period that this decision may start. The bench runs retry sequences in which duty_sel_i changes on the last probe cycle itself, just before that edge, and then again one cycle later, just after it. The expected on/off pattern is computed from the period arithmetic. In the first case the new ratio must shape the following period. In the second case it must be deferred by one full period. A related pair of tests toggles ovl_i inside the probe, so that only the level at the final probe edge decides between restarting and returning to normal operation.

// File: rtl/ovr_pkg.sv
`timescale 1ns/1ps
package ovr_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_OFF  = 2'd1,
    ST_TEST = 2'd2
  } ovr_state_e;

  localparam int unsigned RATIO_W = 4;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd4;
      2'b01:   return 4'd8;
      2'b10:   return 4'd10;
      default: return 4'd15;
    endcase
  endfunction
endpackage

// File: rtl/ovr_slot_cnt.sv
`timescale 1ns/1ps
// Counts cycles inside one test interval; held at zero outside retry.
module ovr_slot_cnt #(
  parameter int unsigned TEST_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned SW = $clog2(TEST_CYC + 1);
  localparam logic [SW-1:0] LAST = SW'(TEST_CYC - 1);

  logic [SW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || last_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + SW'(1);
  end
endmodule

// File: rtl/ovr_ivl_cnt.sv
`timescale 1ns/1ps
// Counts off intervals and holds the ratio captured at period start.
module ovr_ivl_cnt
  import ovr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] sel_i,
  input  logic       step_i,
  output logic       done_o
);
  logic [RATIO_W-1:0] n_q;
  logic [RATIO_W-1:0] ivl_q;

  // last off interval is index N-2
  assign done_o = (ivl_q == (n_q - RATIO_W'(2)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= ratio_of(2'b10);
      ivl_q <= '0;
    end else if (load_i) begin
      n_q   <= ratio_of(sel_i);
      ivl_q <= '0;
    end else if (step_i) begin
      ivl_q <= ivl_q + RATIO_W'(1);
    end
  end
endmodule

// File: rtl/ovr_seq.sv
`timescale 1ns/1ps
module ovr_seq
  import ovr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovl_i,
  input  logic       slot_last_i,
  input  logic       off_done_i,
  output logic       start_o,
  output logic       step_o,
  output ovr_state_e state_o
);
  ovr_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (ovl_i) begin
          st_d    = ST_OFF;
          start_o = 1'b1;
        end
      end
      ST_OFF: begin
        if (slot_last_i && off_done_i) st_d = ST_TEST;
      end
      ST_TEST: begin
        if (slot_last_i) begin
          if (ovl_i) begin
            st_d    = ST_OFF;
            start_o = 1'b1;
          end else begin
            st_d = ST_RUN;
          end
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  assign step_o  = (st_q == ST_OFF) && slot_last_i;
  assign state_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/ovr_retry_timer.sv
`timescale 1ns/1ps
module ovr_retry_timer
  import ovr_pkg::*;
#(
  parameter int unsigned TEST_CYC = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ovl_i,
  input  logic [1:0] duty_sel_i,
  output logic       out_en_o,
  output logic       ovl_stat_o
);
  ovr_state_e state;
  logic       slot_last;
  logic       off_done;
  logic       start;
  logic       step;
  logic       in_retry;

  assign in_retry = (state != ST_RUN);

  ovr_slot_cnt #(.TEST_CYC(TEST_CYC)) u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (in_retry),
    .last_o (slot_last)
  );

  ovr_ivl_cnt u_ivl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .sel_i  (duty_sel_i),
    .step_i (step),
    .done_o (off_done)
  );

  ovr_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ovl_i       (ovl_i),
    .slot_last_i (slot_last),
    .off_done_i  (off_done),
    .start_o     (start),
    .step_o      (step),
    .state_o     (state)
  );

  assign out_en_o   = (state != ST_OFF);
  assign ovl_stat_o = in_retry;
endmodule

// File: rtl/ovr_retry_timer_chk.sv
`timescale 1ns/1ps
module ovr_retry_timer_chk #(
  parameter int unsigned TEST_CYC = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ovl_i,
  input logic out_en_o,
  input logic ovl_stat_o
);
  localparam int unsigned OW = $clog2(16 * TEST_CYC + 1);
  localparam logic [OW-1:0] T_L     = OW'(TEST_CYC);
  localparam logic [OW-1:0] OFF_MAX = OW'(14 * TEST_CYC);
  localparam logic [OW-1:0] OFF_MIN = OW'(3 * TEST_CYC - 1);
  localparam logic [OW-1:0] CAP     = OW'(16 * TEST_CYC);

  logic [OW-1:0] on_cnt, off_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_cnt  <= '0;
      off_cnt <= '0;
    end else begin
      on_cnt  <= (ovl_stat_o && out_en_o) ? ((on_cnt < CAP) ? on_cnt + OW'(1) : on_cnt) : '0;
      off_cnt <= (!out_en_o) ? ((off_cnt < CAP) ? off_cnt + OW'(1) : off_cnt) : '0;
    end
  end

  AST_OFF_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> ovl_stat_o); // R9
  AST_ENTRY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovl_stat_o && ovl_i) |=> (ovl_stat_o && !out_en_o)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovl_stat_o && !ovl_i) |=> (!ovl_stat_o && out_en_o)); // R2
  AST_PULSE_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_stat_o && out_en_o) |-> (on_cnt < T_L)); // R4
  AST_PULSE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovl_stat_o && out_en_o) && !out_en_o) |-> ($past(on_cnt) == T_L - OW'(1))); // R4
  AST_EXIT_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovl_stat_o) |-> (($past(on_cnt) == T_L - OW'(1)) && !$past(ovl_i))); // R7
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ovl_stat_o && out_en_o) && ($past(on_cnt) == T_L - OW'(1)) && $past(ovl_i))
      |-> (!out_en_o && ovl_stat_o)); // R6
  AST_OFF_LONGEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_o |-> (off_cnt < OFF_MAX)); // R5
  AST_OFF_SHORTEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_en_o) && ovl_stat_o) |-> ($past(off_cnt) >= OFF_MIN)); // R5
endmodule

bind ovr_retry_timer ovr_retry_timer_chk #(.TEST_CYC(TEST_CYC)) u_chk (.*);

// File: tb/ovr_retry_timer_tb_top.sv
`timescale 1ns/1ps
module ovr_retry_timer_tb_top;
  localparam int T = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovl = 1'b0;
  logic [1:0] duty = 2'b10;
  logic       en, stat;
  int         errs = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  ovr_retry_timer #(.TEST_CYC(T)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ovl_i      (ovl),
    .duty_sel_i (duty),
    .out_en_o   (en),
    .ovl_stat_o (stat)
  );

  function automatic int nof(input logic [1:0] s);
    case (s)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 10;
      default: return 15;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // k counts cycles from the first cycle of retry; chg_k: negedge where duty switches to s1
  task automatic retry_run(input logic [1:0] s0, input logic [1:0] s1, input int chg_k,
                           input int periods, input string tag);
    int n0, n1, pstart, pn, pcnt;
    string ph;
    n0 = nof(s0); n1 = nof(s1);
    pstart = 0; pn = n0; pcnt = 1;
    @(negedge clk); duty = s0; ovl = 1'b1;
    for (int k = 0; k < 100000; k++) begin
      @(negedge clk);
      if (k == pstart + pn * T) begin
        pstart = k;
        pn = (chg_k < k) ? n1 : n0;
        pcnt++;
      end
      if (k == 0)                         ph = "R3 entry";
      else if (k == pstart)               ph = "R6 restart";
      else if ((k - pstart) >= (pn-1)*T)  ph = "R4 probe";
      else                                ph = "R5 off";
      chk($sformatf("%s %s k=%0d", ph, tag, k), en, 1'((k - pstart) >= (pn - 1) * T));
      chk($sformatf("R9 status %s k=%0d", tag, k), stat, 1'b1);
      if (k == chg_k) duty = s1;
      if (pcnt == periods && k == pstart + pn * T - 1) begin
        ovl = 1'b0;
        break;
      end
    end
    @(negedge clk);
    chk({"R7 exit en ", tag}, en, 1'b1);
    chk({"R7 exit stat ", tag}, stat, 1'b0);
  endtask

  // N=4: probe cycles k=9..11; only the level at k=11 counts
  task automatic probe_glitch(input bit end_high);
    int last;
    last = end_high ? 23 : 11;
    @(negedge clk); duty = 2'b00; ovl = 1'b1;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      chk($sformatf("R6 glitch en k=%0d", k), en, 1'(((k % 12) >= 9)));
      chk($sformatf("R6 glitch stat k=%0d", k), stat, 1'b1);
      if (k == 9)  ovl = 1'b0;
      if (k == 10) ovl = end_high ? 1'b0 : 1'b1;
      if (k == 11) ovl = end_high ? 1'b1 : 1'b0;
      if (k == 23) ovl = 1'b0;
    end
    @(negedge clk);
    chk("R7 glitch exit en", en, 1'b1);
    chk("R7 glitch exit stat", stat, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    #1;
    chk("R1 reset en", en, 1'b1);
    chk("R1 reset stat", stat, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R2 idle en", en, 1'b1);
      chk("R2 idle stat", stat, 1'b0);
      duty = 2'(i);
    end

    for (int s = 0; s < 4; s++)
      retry_run(2'(s), 2'(s), 1000000, 2, $sformatf("R5 sweep sel=%0d", s));

    retry_run(2'b00, 2'b11, 2, 3, "R8 mid-period change");
    retry_run(2'b01, 2'b00, 8 * T - 1, 3, "R8 change before restart edge");
    retry_run(2'b01, 2'b00, 8 * T, 3, "R8 change after restart edge");
    retry_run(2'b11, 2'b10, 15 * T - 1, 2, "R8 longest to default");

    probe_glitch(1'b1);
    probe_glitch(1'b0);

    @(negedge clk); duty = 2'b10; ovl = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 before reset en", en, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset en", en, 1'b1);
    chk("R1 async reset stat", stat, 1'b0);
    ovl = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2 after reset en", en, 1'b1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule